// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts, for a memory instruction entering an out-of-order pipeline, which older in-flight store it should wait for. Instruction addresses are grouped into store sets. A set-ID table is indexed by bits of the instruction address and maps that address to a set number. A last-store table is indexed by set number and records the sequence number and thread of the youngest dispatched store of each set. Each entry in both tables carries a valid bit.

When a load is caught reading memory before an older store that wrote the same location, the two instruction addresses are placed in a common set. From then on, a lookup of either address returns the sequence number of the most recent store dispatched in that set, and the issue logic holds the instruction back until that store issues. Store issue, thread squash and a global clear remove stale producers. A result of zero means the instruction has no predicted dependence.

Every update is applied at a clock edge. The lookup is combinational, so it reflects all updates up to the most recent edge.

Top module: `store_set_pred`

## Requirements
- R1: After a synchronous active-low reset, or in the cycle after `clr` is high, every entry of both tables is invalid and every lookup returns 0.
- R2: The set-ID table index of an address is `(pc >> OFFSET_BITS) & (SSIT_ENTRIES-1)`. A newly allocated set number is `(pc ^ (pc >> 10)) & (LFST_ENTRIES-1)`. Both table sizes are powers of two. With the defaults (OFFSET_BITS=2, 64 and 16 entries), addresses 0x80 and 0x180 share an index, and load addresses 0x404 and 0x15 both hash to set 5.
- R3: A violation report in which neither the store address nor the load address has a valid set-ID entry gives both entries the new set number hashed from the load address.
- R4: A violation report in which exactly one of the two addresses has a valid entry copies that entry's set number to the other address.
- R5: A violation report in which both addresses have valid entries writes the smaller of the two set numbers to both.
- R6: A store insertion whose address has a valid set-ID entry writes its sequence number and thread into the last-store entry of that set, replacing any older value. A lookup of any address in that set then returns that sequence number.
- R7: A store insertion whose address has no valid set-ID entry changes no state.
- R8: A lookup returns 0 when the address has no valid set-ID entry, or when the last-store entry of its set is invalid.
- R9: A store issue whose sequence number equals the recorded last store of its set invalidates that entry. An issue with a different sequence number, or with the store flag low, changes nothing.
- R10: A squash invalidates every last-store entry whose thread equals the squash thread and whose sequence number is strictly greater (unsigned) than the squash number. All other entries stay unchanged.
- R11: A load insertion has no effect on either table.
- R12: When several requests are valid in the same cycle, only the one of highest priority acts. The order is clear, squash, violation, store insertion, store issue.
- R13: A lookup reflects the updates made at the most recent clock edge, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Invalidate both tables |
| viol_vld | input | 1 | Ordering violation report valid |
| viol_st_pc | input | PC_W | Address of the older store in the violation |
| viol_ld_pc | input | PC_W | Address of the younger load in the violation |
| st_ins_vld | input | 1 | Store dispatched |
| st_ins_pc | input | PC_W | Dispatched store address |
| st_ins_seq | input | SEQ_W | Dispatched store sequence number |
| st_ins_tid | input | TID_W | Dispatched store thread |
| ld_ins_vld | input | 1 | Load dispatched (no effect) |
| ld_ins_pc | input | PC_W | Dispatched load address |
| ld_ins_seq | input | SEQ_W | Dispatched load sequence number |
| iss_vld | input | 1 | Instruction issued |
| iss_pc | input | PC_W | Issued instruction address |
| iss_seq | input | SEQ_W | Issued instruction sequence number |
| iss_is_st | input | 1 | Issued instruction is a store |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Entries younger than this are removed |
| lk_pc | input | PC_W | Lookup address |
| lk_seq | output | SEQ_W | Predicted producer store sequence number, 0 if none |

## Verification
The assertions check, on every cycle, the per-table effects of each request. A clear leaves both tables empty. A violation write lands in both set-ID entries. A store insertion is recorded in its set. A matching store issue releases its set. After a squash, no entry of the squashed thread younger than the squash number is left. The bench scenarios show what only a sequence of requests can reveal. These are the exact set numbers chosen by the three merge cases, aliasing through the index mask and the hash, the strict boundary of the squash comparison, the non-effect of load insertion and of unmatched issues, and the priority among requests arriving in the same cycle.

// File: rtl/ssp_pkg.sv
// Package: shared types of the store set predictor.
// Assumes: one request of the enumerated kinds acts per cycle.
package ssp_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLEAR,
        OP_SQUASH,
        OP_VIOL,
        OP_STORE,
        OP_ISSUE
    } ssp_op_e;
endpackage

// File: rtl/ssp_id_table.sv
// Set-ID table: maps an address index to a set number, with a valid bit.
// Has NRD combinational read ports and one write value that is applied to
// two indices (the store and load of a violation).
// Assumes: clr and wr_en are already mutually exclusive upstream.
module ssp_id_table #(
    parameter int ENTRIES = 64,
    parameter int SID_W   = 4,
    parameter int NRD     = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx_a,
    input  logic [IDX_W-1:0]            wr_idx_b,
    input  logic [SID_W-1:0]            wr_sid,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0]              rd_vld,
    output logic [NRD-1:0][SID_W-1:0]   rd_sid
);
    logic [ENTRIES-1:0] vld_q;
    logic [SID_W-1:0]   sid_q [ENTRIES];

    // Valid bits: reset and clear empty the table, a write marks both indices.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx_a] <= 1'b1;
            vld_q[wr_idx_b] <= 1'b1;
        end
    end

    // Set numbers: written alongside the valid bits, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            sid_q[wr_idx_a] <= wr_sid;
            sid_q[wr_idx_b] <= wr_sid;
        end
    end

    // Read ports: one combinational lookup per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_vld[p] = vld_q[rd_idx[p]];
        assign rd_sid[p] = sid_q[rd_idx[p]];
    end

    a_r1_clear_empties_ids: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
    a_r3_write_lands_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (vld_q[$past(wr_idx_a)] && sid_q[$past(wr_idx_a)] == $past(wr_sid)));
    a_r3_write_lands_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (vld_q[$past(wr_idx_b)] && sid_q[$past(wr_idx_b)] == $past(wr_sid)));
endmodule

// File: rtl/ssp_last_store.sv
// Last-store table: for each set, the sequence number and thread of the
// youngest dispatched store, with a valid bit.
// Assumes: sequence numbers grow without wrap; within one cycle the local
// order is clear, squash, insert, issue.
module ssp_last_store #(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 32,
    parameter int TID_W   = 1,
    localparam int SID_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ins_en,
    input  logic [SID_W-1:0]  ins_sid,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [TID_W-1:0]  ins_tid,
    input  logic              iss_en,
    input  logic [SID_W-1:0]  iss_sid,
    input  logic [SEQ_W-1:0]  iss_seq,
    input  logic              sq_en,
    input  logic [TID_W-1:0]  sq_tid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic [SID_W-1:0]  rd_sid,
    output logic              rd_vld,
    output logic [SEQ_W-1:0]  rd_seq
);
    logic [ENTRIES-1:0] vld_q;
    logic [SEQ_W-1:0]   seq_q [ENTRIES];
    logic [TID_W-1:0]   tid_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic sq_kill, ins_hit, iss_hit;

        // Per-entry decode of which request touches this set.
        always_comb begin
            sq_kill = sq_en && vld_q[i] && (tid_q[i] == sq_tid) && (seq_q[i] > sq_seq);
            ins_hit = ins_en && (ins_sid == SID_W'(i));
            iss_hit = iss_en && (iss_sid == SID_W'(i)) && vld_q[i] && (seq_q[i] == iss_seq);
        end

        // Valid bit: set by insertion, dropped by clear, squash or matching issue.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld_q[i] <= 1'b0;
            end else if (sq_en) begin
                if (sq_kill) vld_q[i] <= 1'b0;
            end else if (ins_hit) begin
                vld_q[i] <= 1'b1;
            end else if (iss_hit) begin
                vld_q[i] <= 1'b0;
            end
        end

        // Payload: captured on an insertion that acts this cycle.
        always_ff @(posedge clk) begin
            if (ins_hit && !clr && !sq_en) begin
                seq_q[i] <= ins_seq;
                tid_q[i] <= ins_tid;
            end
        end

        a_r10_squash_removes_young: assert property (@(posedge clk) disable iff (!rst_n)
            sq_en |=> !(vld_q[i] && tid_q[i] == $past(sq_tid) && seq_q[i] > $past(sq_seq)));
    end

    // Read port: one combinational lookup by set number.
    assign rd_vld = vld_q[rd_sid];
    assign rd_seq = seq_q[rd_sid];

    a_r1_clear_empties_stores: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
    a_r6_insert_records: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !clr && !sq_en) |=> (vld_q[$past(ins_sid)] && seq_q[$past(ins_sid)] == $past(ins_seq)));
    a_r9_issue_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_en && !ins_en && !clr && !sq_en && vld_q[iss_sid] && seq_q[iss_sid] == iss_seq)
        |=> !vld_q[$past(iss_sid)]);
endmodule

// File: rtl/store_set_pred.sv
// Store set predictor top: picks the single acting request by priority,
// derives table indices and set numbers from addresses, merges sets on a
// violation and forms the lookup result.
// Assumes: table sizes are powers of two; sequence number 0 is never used
// by a real store.
module store_set_pred
    import ssp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int SEQ_W        = 32,
    parameter int TID_W        = 1,
    parameter int SSIT_ENTRIES = 64,
    parameter int LFST_ENTRIES = 16,
    parameter int OFFSET_BITS  = 2,
    parameter int HASH_SHIFT   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              viol_vld,
    input  logic [PC_W-1:0]   viol_st_pc,
    input  logic [PC_W-1:0]   viol_ld_pc,
    input  logic              st_ins_vld,
    input  logic [PC_W-1:0]   st_ins_pc,
    input  logic [SEQ_W-1:0]  st_ins_seq,
    input  logic [TID_W-1:0]  st_ins_tid,
    input  logic              ld_ins_vld,
    input  logic [PC_W-1:0]   ld_ins_pc,
    input  logic [SEQ_W-1:0]  ld_ins_seq,
    input  logic              iss_vld,
    input  logic [PC_W-1:0]   iss_pc,
    input  logic [SEQ_W-1:0]  iss_seq,
    input  logic              iss_is_st,
    input  logic              sq_vld,
    input  logic [TID_W-1:0]  sq_tid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic [PC_W-1:0]   lk_pc,
    output logic [SEQ_W-1:0]  lk_seq
);
    localparam int IDX_W = $clog2(SSIT_ENTRIES);
    localparam int SID_W = $clog2(LFST_ENTRIES);
    localparam int NRD   = 5;
    localparam int RP_VST = 0, RP_VLD = 1, RP_INS = 2, RP_ISS = 3, RP_LK = 4;

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return IDX_W'(pc >> OFFSET_BITS);
    endfunction

    function automatic logic [SID_W-1:0] sid_of(input logic [PC_W-1:0] pc);
        return SID_W'(pc ^ (pc >> HASH_SHIFT));
    endfunction

    ssp_op_e                     op;
    logic [NRD-1:0][IDX_W-1:0]   id_rd_idx;
    logic [NRD-1:0]              id_rd_vld;
    logic [NRD-1:0][SID_W-1:0]   id_rd_sid;
    logic [SID_W-1:0]            merge_sid;
    logic                        ls_vld;
    logic [SEQ_W-1:0]            ls_seq;
    logic                        unused_ld;

    assign unused_ld = ^{ld_ins_vld, ld_ins_pc, ld_ins_seq};

    // Request arbitration: only the highest-priority request acts.
    always_comb begin
        if (clr)             op = OP_CLEAR;
        else if (sq_vld)     op = OP_SQUASH;
        else if (viol_vld)   op = OP_VIOL;
        else if (st_ins_vld) op = OP_STORE;
        else if (iss_vld)    op = OP_ISSUE;
        else                 op = OP_NONE;
    end

    // Index generation for every set-ID read port.
    always_comb begin
        id_rd_idx[RP_VST] = idx_of(viol_st_pc);
        id_rd_idx[RP_VLD] = idx_of(viol_ld_pc);
        id_rd_idx[RP_INS] = idx_of(st_ins_pc);
        id_rd_idx[RP_ISS] = idx_of(iss_pc);
        id_rd_idx[RP_LK]  = idx_of(lk_pc);
    end

    // Violation merge: allocate, copy, or take the smaller set number.
    always_comb begin
        unique case ({id_rd_vld[RP_VST], id_rd_vld[RP_VLD]})
            2'b00:   merge_sid = sid_of(viol_ld_pc);
            2'b10:   merge_sid = id_rd_sid[RP_VST];
            2'b01:   merge_sid = id_rd_sid[RP_VLD];
            default: merge_sid = (id_rd_sid[RP_VST] < id_rd_sid[RP_VLD]) ?
                                 id_rd_sid[RP_VST] : id_rd_sid[RP_VLD];
        endcase
    end

    ssp_id_table #(
        .ENTRIES (SSIT_ENTRIES),
        .SID_W   (SID_W),
        .NRD     (NRD)
    ) id_tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (op == OP_CLEAR),
        .wr_en    (op == OP_VIOL),
        .wr_idx_a (id_rd_idx[RP_VST]),
        .wr_idx_b (id_rd_idx[RP_VLD]),
        .wr_sid   (merge_sid),
        .rd_idx   (id_rd_idx),
        .rd_vld   (id_rd_vld),
        .rd_sid   (id_rd_sid)
    );

    ssp_last_store #(
        .ENTRIES (LFST_ENTRIES),
        .SEQ_W   (SEQ_W),
        .TID_W   (TID_W)
    ) last_st_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (op == OP_CLEAR),
        .ins_en  ((op == OP_STORE) && id_rd_vld[RP_INS]),
        .ins_sid (id_rd_sid[RP_INS]),
        .ins_seq (st_ins_seq),
        .ins_tid (st_ins_tid),
        .iss_en  ((op == OP_ISSUE) && iss_is_st && id_rd_vld[RP_ISS]),
        .iss_sid (id_rd_sid[RP_ISS]),
        .iss_seq (iss_seq),
        .sq_en   (op == OP_SQUASH),
        .sq_tid  (sq_tid),
        .sq_seq  (sq_seq),
        .rd_sid  (id_rd_sid[RP_LK]),
        .rd_vld  (ls_vld),
        .rd_seq  (ls_seq)
    );

    // Lookup result: producer sequence number, or zero with no dependence.
    assign lk_seq = (id_rd_vld[RP_LK] && ls_vld) ? ls_seq : '0;

    a_r8_nonzero_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_seq != '0) |-> (id_rd_vld[RP_LK] && ls_vld));
endmodule

// File: tb/store_set_pred_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the store set predictor: one task per scenario.
module store_set_pred_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        viol_vld = 1'b0;
    logic [31:0] viol_st_pc = '0, viol_ld_pc = '0;
    logic        st_ins_vld = 1'b0;
    logic [31:0] st_ins_pc = '0, st_ins_seq = '0;
    logic        st_ins_tid = 1'b0;
    logic        ld_ins_vld = 1'b0;
    logic [31:0] ld_ins_pc = '0, ld_ins_seq = '0;
    logic        iss_vld = 1'b0;
    logic [31:0] iss_pc = '0, iss_seq = '0;
    logic        iss_is_st = 1'b0;
    logic        sq_vld = 1'b0;
    logic        sq_tid = 1'b0;
    logic [31:0] sq_seq = '0;
    logic [31:0] lk_pc = '0;
    logic [31:0] lk_seq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    store_set_pred dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .viol_vld(viol_vld), .viol_st_pc(viol_st_pc), .viol_ld_pc(viol_ld_pc),
        .st_ins_vld(st_ins_vld), .st_ins_pc(st_ins_pc), .st_ins_seq(st_ins_seq),
        .st_ins_tid(st_ins_tid),
        .ld_ins_vld(ld_ins_vld), .ld_ins_pc(ld_ins_pc), .ld_ins_seq(ld_ins_seq),
        .iss_vld(iss_vld), .iss_pc(iss_pc), .iss_seq(iss_seq), .iss_is_st(iss_is_st),
        .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .lk_pc(lk_pc), .lk_seq(lk_seq)
    );

    // Ends one driven cycle: let the edge pass, then drop every strobe.
    task automatic step();
        @(negedge clk);
        clr = 0; viol_vld = 0; st_ins_vld = 0; ld_ins_vld = 0; iss_vld = 0; sq_vld = 0;
    endtask

    task automatic do_clear();
        clr = 1; step();
    endtask

    task automatic do_viol(input logic [31:0] st, input logic [31:0] ld);
        viol_vld = 1; viol_st_pc = st; viol_ld_pc = ld; step();
    endtask

    task automatic do_ins(input logic [31:0] pc, input logic [31:0] seq, input logic tid);
        st_ins_vld = 1; st_ins_pc = pc; st_ins_seq = seq; st_ins_tid = tid; step();
    endtask

    task automatic do_iss(input logic [31:0] pc, input logic [31:0] seq, input logic is_st);
        iss_vld = 1; iss_pc = pc; iss_seq = seq; iss_is_st = is_st; step();
    endtask

    task automatic do_sq(input logic tid, input logic [31:0] seq);
        sq_vld = 1; sq_tid = tid; sq_seq = seq; step();
    endtask

    // Lookup at mid-cycle and compare against the expected producer.
    task automatic look(input logic [31:0] pc, input logic [31:0] exp, input string req);
        lk_pc = pc;
        #1;
        n_tests++;
        if (lk_seq !== exp) begin
            n_fail++;
            $display("FAIL %s lookup pc=%h actual=%0d expected=%0d", req, pc, lk_seq, exp);
        end
    endtask

    // R1: empty after reset and after clear.
    task automatic t_reset_clear();
        look(32'h20, 0, "R1");
        look(32'h44, 0, "R1");
        do_viol(32'h20, 32'h44);
        do_ins(32'h20, 3, 0);
        look(32'h44, 3, "R6");
        do_clear();
        look(32'h44, 0, "R1");
        look(32'h20, 0, "R1");
    endtask

    // R3, R7, R8, R6, R2, R13: allocation, hash, index aliasing.
    task automatic t_alloc();
        do_clear();
        do_ins(32'h20, 5, 0);
        look(32'h20, 0, "R7");
        do_viol(32'h20, 32'h44);
        look(32'h44, 0, "R8");
        do_ins(32'h20, 7, 0);
        look(32'h44, 7, "R13");
        look(32'h20, 7, "R6");
        do_ins(32'h20, 8, 0);
        look(32'h44, 8, "R6");
        // sets hashed from 0x404 and 0x15 are both 5 (R3 uses the load hash)
        do_viol(32'h80, 32'h404);
        do_viol(32'h100, 32'h15);
        do_ins(32'h80, 9, 0);
        look(32'h100, 9, "R3");
        look(32'h15, 9, "R2");
        look(32'h180, 9, "R2");
        look(32'h44, 8, "R8");
        look(32'h50, 0, "R8");
    endtask

    // R4: one side valid, the set number is copied in both directions.
    task automatic t_copy();
        do_clear();
        do_viol(32'h20, 32'h44);
        do_viol(32'h20, 32'h60);
        do_ins(32'h20, 11, 0);
        look(32'h60, 11, "R4");
        do_viol(32'h70, 32'h44);
        do_ins(32'h70, 12, 0);
        look(32'h44, 12, "R4");
        look(32'h60, 12, "R4");
    endtask

    // R5: both valid, the smaller set number wins.
    task automatic t_merge();
        do_clear();
        do_viol(32'h200, 32'h2C);   // set 12
        do_viol(32'h30, 32'h12);    // set 2
        do_viol(32'h200, 32'h12);   // both become 2
        do_ins(32'h200, 20, 0);
        look(32'h30, 20, "R5");
        look(32'h12, 20, "R5");
        look(32'h2C, 0, "R5");
    endtask

    // R9: only a matching store issue releases the set.
    task automatic t_issue();
        do_clear();
        do_viol(32'h20, 32'h44);
        do_ins(32'h20, 30, 0);
        do_iss(32'h20, 30, 0);
        look(32'h44, 30, "R9");
        do_iss(32'h20, 29, 1);
        look(32'h44, 30, "R9");
        do_iss(32'h20, 30, 1);
        look(32'h44, 0, "R9");
    endtask

    // R10: squash by thread, strictly younger only.
    task automatic t_squash();
        do_clear();
        do_viol(32'h20, 32'h44);    // set 4
        do_viol(32'h30, 32'h12);    // set 2
        do_viol(32'h80, 32'h15);    // set 5
        do_ins(32'h20, 40, 1);
        do_ins(32'h30, 45, 0);
        do_ins(32'h80, 50, 1);
        do_sq(1, 45);
        look(32'h15, 0, "R10");
        look(32'h44, 40, "R10");
        look(32'h12, 45, "R10");
        do_sq(0, 45);
        look(32'h12, 45, "R10");
        do_sq(0, 44);
        look(32'h12, 0, "R10");
        look(32'h44, 40, "R10");
    endtask

    // R11: load insertion touches neither table.
    task automatic t_load();
        do_clear();
        do_viol(32'h20, 32'h44);
        do_ins(32'h20, 60, 0);
        ld_ins_vld = 1; ld_ins_pc = 32'h44; ld_ins_seq = 99; step();
        look(32'h44, 60, "R11");
        ld_ins_vld = 1; ld_ins_pc = 32'h50; ld_ins_seq = 98; step();
        do_ins(32'h50, 61, 0);
        look(32'h50, 0, "R11");
    endtask

    // R12: simultaneous requests, only the top-priority one acts.
    task automatic t_priority();
        do_clear();
        do_viol(32'h20, 32'h44);
        do_ins(32'h20, 60, 0);
        clr = 1; st_ins_vld = 1; st_ins_pc = 32'h20; st_ins_seq = 65; st_ins_tid = 0; step();
        look(32'h20, 0, "R12");
        do_viol(32'h20, 32'h44);
        do_ins(32'h20, 60, 0);
        sq_vld = 1; sq_tid = 0; sq_seq = 100;
        st_ins_vld = 1; st_ins_pc = 32'h20; st_ins_seq = 70; st_ins_tid = 0; step();
        look(32'h44, 60, "R12");
        do_clear();
        viol_vld = 1; viol_st_pc = 32'h20; viol_ld_pc = 32'h44;
        st_ins_vld = 1; st_ins_pc = 32'h20; st_ins_seq = 80; st_ins_tid = 0; step();
        look(32'h44, 0, "R12");
        st_ins_vld = 1; st_ins_pc = 32'h20; st_ins_seq = 81; st_ins_tid = 0;
        iss_vld = 1; iss_pc = 32'h20; iss_seq = 81; iss_is_st = 1; step();
        look(32'h44, 81, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_clear();
        t_alloc();
        t_copy();
        t_merge();
        t_issue();
        t_squash();
        t_load();
        t_priority();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule